// File: doc/BRIEF.md
# Instruction Queue Doorbell and Error Interrupt Controller

This block holds the per-queue control state that sits between software and an instruction fetch engine. Software posts work by writing a number of 64-bit instruction words to a doorbell port. The block adds that number to a pending-word counter, and the fetch side removes one instruction's worth of words each time it consumes an instruction. A five-bit interrupt status register records the mailbox event, doorbell overflow, two bus response errors and engine software errors. A matching enable register masks these bits onto a single interrupt line. The queue enable bit is owned by software, but hardware clears it when a serious error occurs, unless the continue-on-error input is held high.

The queue enable is a three-state machine. In ST_IDLE the queue is off because software turned it off or never turned it on. In ST_ACTIVE the queue is running. In ST_FAULTED the queue was stopped by an error. The transitions are as follows. T_START goes from ST_IDLE to ST_ACTIVE on a software write of 1. T_STOP goes from ST_ACTIVE to ST_IDLE on a software write of 0. T_FAULT goes from ST_ACTIVE to ST_FAULTED on a fault event; a fault event also sends a same-cycle start from ST_IDLE to ST_FAULTED. T_RESUME goes from ST_FAULTED to ST_ACTIVE on a software write of 1. T_CLEAR goes from ST_FAULTED to ST_IDLE on a software write of 0. The queue enable output is high only in ST_ACTIVE.

Top module: `qdb_irq_ctrl`

## Requirements
- R1: After reset the word count, status, enables, interrupt line and queue enable are all zero.
- R2: A doorbell write adds the written value to the count, rounded down to a multiple of 8, and the sum is visible on the clock after the write.
- R3: A consume pulse removes 8 words when the current count is at least 8 and is ignored otherwise. An add and a consume in the same cycle give count + add - 8 when that condition holds.
- R4: When count plus the aligned add reaches 2^20 or more, the count wraps modulo 2^20 and status bit 1 (doorbell overflow) is set.
- R5: A doorbell value whose low three bits are nonzero sets status bit 4 (software error) as well as adding the rounded value.
- R6: Status bit positions are: bit 0 mailbox write, bit 2 read-response error, bit 3 write-response error, bit 4 engine software error. Each event pulse sets its bit on the next clock.
- R7: A write-1-to-clear on the status register clears each bit written as 1. A set event for the same bit in the same cycle wins over the clear.
- R8: A write-1-to-set on the status register sets bits exactly as hardware events do, including their effect on the queue enable.
- R9: Enable bits use the status layout. Write-1-to-set sets them, write-1-to-clear clears them, zero bits have no effect, and set wins when both arrive in the same cycle.
- R10: The interrupt line is high exactly when some status bit and its enable are both 1, in the same cycle as the registers.
- R11: A software queue-enable write loads the written bit into the queue enable on the next clock.
- R12: With continue-on-error low, any set of status bit 1, 2 or 3 drops the queue enable on the next clock, overriding a simultaneous software enable. Bits 0 and 4 never affect the queue enable.
- R13: With continue-on-error high, error events leave the queue enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbell_wr | input | 1 | Doorbell write strobe |
| dbell_wdata | input | 20 | Number of words to add |
| consume | input | 1 | One instruction taken by the fetch side |
| int_w1c_wr | input | 1 | Status write-1-to-clear strobe |
| int_w1s_wr | input | 1 | Status write-1-to-set strobe |
| int_wdata | input | 5 | Data for status writes |
| ena_w1s_wr | input | 1 | Enable write-1-to-set strobe |
| ena_w1c_wr | input | 1 | Enable write-1-to-clear strobe |
| ena_wdata | input | 5 | Data for enable writes |
| qen_wr | input | 1 | Queue enable write strobe |
| qen_wdata | input | 1 | Queue enable value |
| cont_on_err | input | 1 | Continue-on-error level |
| mbox_wr | input | 1 | Mailbox written pulse |
| ev_rd_err | input | 1 | Instruction read-response error pulse |
| ev_wr_err | input | 1 | Result write-response error pulse |
| ev_sw_err | input | 1 | Engine software error pulse |
| dbell_count | output | 20 | Pending instruction words |
| int_status | output | 5 | Interrupt status bits |
| int_enables | output | 5 | Interrupt enable bits |
| irq | output | 1 | Combined masked interrupt |
| queue_en | output | 1 | Queue enable |

## Verification
Two pairs of functions can collide in one cycle. The first is a doorbell add with an instruction consume. The second is a status set, from an event or an overflow, with a software clear or a software enable of the queue. The bench drives each pair in the same cycle, both with directed stimulus and inside a pseudo-random stretch. A behavioural model computes the expected state from the requirements, and the design's outputs are compared with it after every clock. The outcome is judged by whether the count reflects both operations, and by whether the set beats the clear and the fault beats the software enable.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
    localparam int IRQ_W     = 5;
    localparam int IDX_MBOX  = 0;
    localparam int IDX_DOVF  = 1;
    localparam int IDX_RDERR = 2;
    localparam int IDX_WRERR = 3;
    localparam int IDX_SWERR = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_FAULTED = 2'd2
    } qstate_e;
endpackage

// File: rtl/qdb_dbell_counter.sv
module qdb_dbell_counter #(
    parameter int CNT_W      = 20,
    parameter int INST_WORDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_wr,
    input  logic [CNT_W-1:0] add_words,
    input  logic             consume,
    output logic [CNT_W-1:0] count,
    output logic             ovf_ev,
    output logic             misalign_ev
);
    localparam int ALIGN_BITS = $clog2(INST_WORDS);

    logic [CNT_W-1:0] add_aligned;
    logic [CNT_W:0]   sum;
    logic             take;
    logic [CNT_W-1:0] sub_words;
    logic [CNT_W-1:0] count_nx;

    always_comb begin
        add_aligned = add_wr ? {add_words[CNT_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}} : '0;
        sum         = {1'b0, count} + {1'b0, add_aligned};
        take        = consume && (|count[CNT_W-1:ALIGN_BITS]);
        sub_words   = take ? CNT_W'(INST_WORDS) : '0;
        count_nx    = sum[CNT_W-1:0] - sub_words;
        ovf_ev      = sum[CNT_W];
        misalign_ev = add_wr && (|add_words[ALIGN_BITS-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nx;
    end

    // R2: with no add and no consume the count holds
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_wr && !consume) |=> $stable(count));

    // R3: consume on fewer than one instruction of words is ignored
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !add_wr && (count < CNT_W'(INST_WORDS))) |=> $stable(count));

    // R3: a lone consume with enough words removes exactly one instruction
    assert_consume_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !add_wr && (count >= CNT_W'(INST_WORDS)))
        |=> (count == $past(count) - CNT_W'(INST_WORDS)));
endmodule

// File: rtl/qdb_irq_regs.sv
module qdb_irq_regs
    import qdb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mbox_ev,
    input  logic             ovf_ev,
    input  logic             rd_err_ev,
    input  logic             wr_err_ev,
    input  logic             sw_err_ev,
    input  logic             misalign_ev,
    input  logic             int_w1c_wr,
    input  logic             int_w1s_wr,
    input  logic [IRQ_W-1:0] int_wdata,
    input  logic             ena_w1s_wr,
    input  logic             ena_w1c_wr,
    input  logic [IRQ_W-1:0] ena_wdata,
    output logic [IRQ_W-1:0] status,
    output logic [IRQ_W-1:0] enables,
    output logic             irq,
    output logic             err_set
);
    logic [IRQ_W-1:0] hw_set;
    logic [IRQ_W-1:0] set_vec;
    logic [IRQ_W-1:0] st_clr;
    logic [IRQ_W-1:0] en_set;
    logic [IRQ_W-1:0] en_clr;

    always_comb begin
        hw_set            = '0;
        hw_set[IDX_MBOX]  = mbox_ev;
        hw_set[IDX_DOVF]  = ovf_ev;
        hw_set[IDX_RDERR] = rd_err_ev;
        hw_set[IDX_WRERR] = wr_err_ev;
        hw_set[IDX_SWERR] = sw_err_ev || misalign_ev;
        set_vec = hw_set | (int_w1s_wr ? int_wdata : '0);
        st_clr  = int_w1c_wr ? int_wdata : '0;
        en_set  = ena_w1s_wr ? ena_wdata : '0;
        en_clr  = ena_w1c_wr ? ena_wdata : '0;
        err_set = set_vec[IDX_DOVF] || set_vec[IDX_RDERR] || set_vec[IDX_WRERR];
        irq     = |(status & enables);
    end

    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i]  <= 1'b0;
                enables[i] <= 1'b0;
            end else begin
                status[i]  <= (status[i] & ~st_clr[i]) | set_vec[i];
                enables[i] <= (enables[i] & ~en_clr[i]) | en_set[i];
            end
        end
    end

    // R4: an overflowing add raises the overflow bit
    assert_ovf_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> status[IDX_DOVF]);

    // R6: a mailbox write raises bit 0
    assert_mbox_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_ev |=> status[IDX_MBOX]);

    // R7: a clear with no competing set drops the mailbox bit
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_w1c_wr && int_wdata[IDX_MBOX] && !mbox_ev && !int_w1s_wr)
        |=> !status[IDX_MBOX]);

    // R9: every enable written with 1 is set afterwards
    assert_en_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ena_w1s_wr |=> ((enables & $past(ena_wdata)) == $past(ena_wdata)));
endmodule

// File: rtl/qdb_queue_fsm.sv
module qdb_queue_fsm
    import qdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qen_wr,
    input  logic qen_wdata,
    input  logic err_set,
    input  logic cont_on_err,
    output logic queue_en
);
    qstate_e state, state_nx;
    logic    fault;
    logic    sw_on;
    logic    sw_off;

    always_comb begin
        fault    = err_set && !cont_on_err;
        sw_on    = qen_wr && qen_wdata;
        sw_off   = qen_wr && !qen_wdata;
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (sw_on) state_nx = fault ? ST_FAULTED : ST_ACTIVE;   // T_START
            end
            ST_ACTIVE: begin
                if (fault)       state_nx = ST_FAULTED;                 // T_FAULT
                else if (sw_off) state_nx = ST_IDLE;                    // T_STOP
            end
            ST_FAULTED: begin
                if (sw_off)                state_nx = ST_IDLE;          // T_CLEAR
                else if (sw_on && !fault)  state_nx = ST_ACTIVE;        // T_RESUME
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        queue_en = (state == ST_ACTIVE);
    end

    // R12: a fault with continue-on-error low stops the queue
    assert_fault_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set && !cont_on_err) |=> !queue_en);

    // R13: continue-on-error keeps the queue enable where software left it
    assert_cont_keeps_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_on_err && !qen_wr) |=> $stable(queue_en));

    // R11: a software write of 1 without a fault starts the queue
    assert_sw_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (qen_wr && qen_wdata && !(err_set && !cont_on_err)) |=> queue_en);
endmodule

// File: rtl/qdb_irq_ctrl.sv
module qdb_irq_ctrl
    import qdb_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int INST_WORDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbell_wr,
    input  logic [CNT_W-1:0] dbell_wdata,
    input  logic             consume,
    input  logic             int_w1c_wr,
    input  logic             int_w1s_wr,
    input  logic [IRQ_W-1:0] int_wdata,
    input  logic             ena_w1s_wr,
    input  logic             ena_w1c_wr,
    input  logic [IRQ_W-1:0] ena_wdata,
    input  logic             qen_wr,
    input  logic             qen_wdata,
    input  logic             cont_on_err,
    input  logic             mbox_wr,
    input  logic             ev_rd_err,
    input  logic             ev_wr_err,
    input  logic             ev_sw_err,
    output logic [CNT_W-1:0] dbell_count,
    output logic [IRQ_W-1:0] int_status,
    output logic [IRQ_W-1:0] int_enables,
    output logic             irq,
    output logic             queue_en
);
    logic ovf_ev;
    logic misalign_ev;
    logic err_set;

    qdb_dbell_counter #(
        .CNT_W      (CNT_W),
        .INST_WORDS (INST_WORDS)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .add_wr      (dbell_wr),
        .add_words   (dbell_wdata),
        .consume     (consume),
        .count       (dbell_count),
        .ovf_ev      (ovf_ev),
        .misalign_ev (misalign_ev)
    );

    qdb_irq_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .mbox_ev     (mbox_wr),
        .ovf_ev      (ovf_ev),
        .rd_err_ev   (ev_rd_err),
        .wr_err_ev   (ev_wr_err),
        .sw_err_ev   (ev_sw_err),
        .misalign_ev (misalign_ev),
        .int_w1c_wr  (int_w1c_wr),
        .int_w1s_wr  (int_w1s_wr),
        .int_wdata   (int_wdata),
        .ena_w1s_wr  (ena_w1s_wr),
        .ena_w1c_wr  (ena_w1c_wr),
        .ena_wdata   (ena_wdata),
        .status      (int_status),
        .enables     (int_enables),
        .irq         (irq),
        .err_set     (err_set)
    );

    qdb_queue_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .qen_wr      (qen_wr),
        .qen_wdata   (qen_wdata),
        .err_set     (err_set),
        .cont_on_err (cont_on_err),
        .queue_en    (queue_en)
    );

    // R5: a misaligned doorbell value raises the software error bit
    assert_misalign_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbell_wr && (dbell_wdata[2:0] != 3'b000)) |=> int_status[IDX_SWERR]);
endmodule

// File: tb/qdb_irq_ctrl_bench.sv
module qdb_irq_ctrl_bench;
    localparam int CW = 20;
    localparam int MODV = 1 << CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbell_wr = 0, consume = 0, int_w1c_wr = 0, int_w1s_wr = 0;
    logic ena_w1s_wr = 0, ena_w1c_wr = 0, qen_wr = 0, qen_wdata = 0;
    logic cont_on_err = 0, mbox_wr = 0, ev_rd_err = 0, ev_wr_err = 0, ev_sw_err = 0;
    logic [CW-1:0] dbell_wdata = '0;
    logic [4:0] int_wdata = '0, ena_wdata = '0;
    logic [CW-1:0] dbell_count;
    logic [4:0] int_status, int_enables;
    logic irq, queue_en;

    always #10 clk = ~clk;

    qdb_irq_ctrl u_qdb_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .dbell_wr(dbell_wr), .dbell_wdata(dbell_wdata),
        .consume(consume), .int_w1c_wr(int_w1c_wr), .int_w1s_wr(int_w1s_wr),
        .int_wdata(int_wdata), .ena_w1s_wr(ena_w1s_wr), .ena_w1c_wr(ena_w1c_wr),
        .ena_wdata(ena_wdata), .qen_wr(qen_wr), .qen_wdata(qen_wdata),
        .cont_on_err(cont_on_err), .mbox_wr(mbox_wr), .ev_rd_err(ev_rd_err),
        .ev_wr_err(ev_wr_err), .ev_sw_err(ev_sw_err), .dbell_count(dbell_count),
        .int_status(int_status), .int_enables(int_enables), .irq(irq), .queue_en(queue_en)
    );

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt = 0;
    bit [4:0] m_st = '0, m_en = '0;
    bit m_q = 0;

    task automatic compare();
        bit m_irq;
        m_irq = |(m_st & m_en);
        n_checks++;
        if (dbell_count !== CW'(m_cnt) || int_status !== m_st || int_enables !== m_en ||
            irq !== m_irq || queue_en !== m_q) begin
            n_fail++;
            $display("FAIL %s: count=%0d/%0d status=%b/%b enables=%b/%b irq=%b/%b qen=%b/%b (actual/expected)",
                     cur_req, dbell_count, m_cnt, int_status, m_st, int_enables, m_en,
                     irq, m_irq, queue_en, m_q);
        end
    endtask

    task automatic clear_pulses();
        dbell_wr = 0; consume = 0; int_w1c_wr = 0; int_w1s_wr = 0;
        ena_w1s_wr = 0; ena_w1c_wr = 0; qen_wr = 0; mbox_wr = 0;
        ev_rd_err = 0; ev_wr_err = 0; ev_sw_err = 0;
        dbell_wdata = '0; int_wdata = '0; ena_wdata = '0; qen_wdata = 0;
    endtask

    // compute the model's next state from the driven inputs, clock once, compare
    task automatic cyc();
        int add, sum, nc;
        bit ovf, mis;
        bit [4:0] setv, nst, nen;
        bit nq;
        add  = dbell_wr ? (int'(dbell_wdata) & ~7) : 0;
        mis  = dbell_wr && (dbell_wdata[2:0] != 3'b000);
        sum  = m_cnt + add;
        ovf  = (sum >= MODV);
        if (consume && m_cnt >= 8) sum = sum - 8;
        nc   = sum % MODV;
        setv = {ev_sw_err | mis, ev_wr_err, ev_rd_err, ovf, mbox_wr};
        if (int_w1s_wr) setv = setv | int_wdata;
        nst  = (m_st & ~(int_w1c_wr ? int_wdata : 5'b0)) | setv;
        nen  = (m_en & ~(ena_w1c_wr ? ena_wdata : 5'b0)) | (ena_w1s_wr ? ena_wdata : 5'b0);
        nq   = m_q;
        if (qen_wr) nq = qen_wdata;
        if (!cont_on_err && (setv[1] || setv[2] || setv[3])) nq = 0;
        @(posedge clk);
        @(negedge clk);
        m_cnt = nc; m_st = nst; m_en = nen; m_q = nq;
        compare();
        clear_pulses();
    endtask

    task automatic add_db(input int v);
        dbell_wr = 1; dbell_wdata = CW'(v); cyc();
    endtask

    task automatic q_write(input bit v);
        qen_wr = 1; qen_wdata = v; cyc();
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1"; compare();
        rst_n = 1;
        cyc();

        cur_req = "R11"; q_write(1); cyc();
        cur_req = "R2"; add_db(16); add_db(64); cyc();
        cur_req = "R3"; consume = 1; cyc(); consume = 1; cyc();
        cur_req = "R3"; dbell_wr = 1; dbell_wdata = 24; consume = 1; cyc();
        cur_req = "R3"; for (int i = 0; i < 14; i++) begin consume = 1; cyc(); end
        cur_req = "R3"; consume = 1; cyc();   // at zero: ignored
        cur_req = "R5"; add_db(13); add_db(5);
        cur_req = "R12"; cyc();               // software error leaves queue on
        cur_req = "R9"; ena_w1s_wr = 1; ena_wdata = 5'b10000; cyc();
        cur_req = "R10"; cyc();
        cur_req = "R9"; ena_w1s_wr = 1; ena_wdata = 5'b00000; cyc();
        ena_w1c_wr = 1; ena_wdata = 5'b00000; cyc();
        ena_w1s_wr = 1; ena_w1c_wr = 1; ena_wdata = 5'b00011; cyc();
        cur_req = "R7"; int_w1c_wr = 1; int_wdata = 5'b10000; cyc();
        cur_req = "R10"; cyc();
        cur_req = "R7"; ev_sw_err = 1; int_w1c_wr = 1; int_wdata = 5'b10000; cyc();
        cur_req = "R6"; mbox_wr = 1; cyc();
        cur_req = "R10"; int_w1c_wr = 1; int_wdata = 5'b11111; cyc();
        cur_req = "R6"; ev_rd_err = 1; cyc();
        cur_req = "R12"; cyc();
        cur_req = "R11"; q_write(1);
        cur_req = "R12"; ev_wr_err = 1; qen_wr = 1; qen_wdata = 1; cyc();
        cur_req = "R11"; q_write(1);
        cur_req = "R8"; int_w1s_wr = 1; int_wdata = 5'b00010; cyc();
        cur_req = "R8"; q_write(1); int_w1s_wr = 1; int_wdata = 5'b10001; cyc();
        cur_req = "R13"; cont_on_err = 1; ev_rd_err = 1; cyc();
        ev_wr_err = 1; cyc(); int_w1s_wr = 1; int_wdata = 5'b01110; cyc();
        cont_on_err = 0;
        cur_req = "R4"; int_w1c_wr = 1; int_wdata = 5'b11111; cyc();
        add_db(MODV - 8); add_db(32); cyc();
        cur_req = "R4"; add_db(MODV - m_cnt); cyc();
        cur_req = "R3"; q_write(1);
        dbell_wr = 1; dbell_wdata = CW'(MODV - 8); cyc();
        cur_req = "R4"; dbell_wr = 1; dbell_wdata = 16; consume = 1; cyc();

        cur_req = "R12";
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 64;
            cont_on_err = (r % 7 == 0);
            if (r < 20) begin dbell_wr = 1; dbell_wdata = CW'($urandom % 4096); end
            if (r % 3 == 0) consume = 1;
            if (r % 11 == 0) mbox_wr = 1;
            if (r == 13) ev_rd_err = 1;
            if (r == 29) ev_wr_err = 1;
            if (r == 31) ev_sw_err = 1;
            if (r % 5 == 0) begin int_w1c_wr = 1; int_wdata = 5'($urandom); end
            if (r == 40) begin int_w1s_wr = 1; int_wdata = 5'($urandom); end
            if (r % 9 == 0) begin ena_w1s_wr = 1; ena_wdata = 5'($urandom); end
            if (r % 13 == 0) begin ena_w1c_wr = 1; ena_wdata = 5'($urandom); end
            if (r % 4 == 1) begin qen_wr = 1; qen_wdata = 1; end
            if (r == 62) begin qen_wr = 1; qen_wdata = 0; end
            cyc();
        end
        cont_on_err = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule